// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Matcher

This block listens to an open-drain two-wire serial bus (clock line and data line) while the device acts as a slave. It finds Start and Stop conditions on the already-synchronised line levels. After every Start it shifts in the address byte, most significant bit first. When the eighth bit has arrived, it compares the seven address bits with a programmed own address. If they agree and address matching is enabled, it raises a match flag.

A busy flag rises at each Start and stays up until the address byte is complete. Software reads the match flag only after busy has dropped. The eighth bit gives the transfer direction. It is captured and presented on its own output, but it takes no part in the comparison. A repeated Start begins the address phase again. A Stop, or clearing the module enable, returns the block to idle.

Top module: `addr_match_top`

## Requirements
- R1: During and directly after reset, `match_o`, `busy_o`, `rw_o` and `addr_o` are all zero. The internal record of the previous line levels resets to the idle (high) state.
- R2: A Start is detected when the data line goes from 1 to 0 while the clock line is 1 in both the previous and the current cycle. In the cycle after the Start is sampled, `busy_o` is 1 and `match_o` is 0.
- R3: Address bits are sampled on rising edges of the clock line. The first bit after a Start lands in `addr_o[6]` and the seventh in `addr_o[0]`. `addr_o` updates when the eighth bit is sampled.
- R4: When the eighth bit is sampled, `match_o` becomes 1 if the seven received bits equal `own_addr_i` and `match_en_i` is 1. Otherwise it becomes 0.
- R5: While `match_en_i` is 0, no comparison takes place and `match_o` never rises.
- R6: `busy_o` falls in the same cycle that `match_o` and `addr_o` take their final values, which is the cycle after the eighth rising clock edge.
- R7: The eighth bit appears on `rw_o`. Its value does not affect `match_o`.
- R8: A repeated Start during or after the address phase discards any partial address and begins a fresh eight-bit capture.
- R9: A Stop is detected when the data line goes from 0 to 1 while the clock line is high. It clears `match_o` and `busy_o` in the next cycle.
- R10: While `mod_en_i` is 0, `match_o` and `busy_o` are 0 and all bus activity is ignored. `addr_o` and `rw_o` keep their values.
- R11: Once the address phase ends, further clock edges leave `addr_o`, `rw_o` and `match_o` unchanged until the next Start, Stop or disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock line level |
| sda_i | input | 1 | Synchronised bus data line level |
| own_addr_i | input | 7 | Programmed own slave address |
| match_en_i | input | 1 | Enables the address comparison |
| mod_en_i | input | 1 | Module enable; 0 forces idle |
| match_o | output | 1 | Address matched in the last address phase |
| busy_o | output | 1 | Address phase in progress |
| addr_o | output | 7 | Last captured seven-bit address |
| rw_o | output | 1 | Last captured direction bit |

## Verification
The bench targets bit order. A single-bit address such as 0x01 would read back as 0x40 if the shift direction were reversed. It sends pairs of addresses that differ only in the direction bit or only in the last address bit. A design that compared eight bits, or too few, would give the wrong match result on one of these pairs. A repeated Start is placed after a partial address, so a design that kept stale bits would misalign the byte. Clock pulses are sent after the address phase has ended, and a design that kept shifting would corrupt `addr_o`. Stops and disables are applied in the middle of an address, so a design that failed to clear state would be left with `busy_o` stuck high.

// File: rtl/sam_pkg.sv
package sam_pkg;
    localparam int SAM_AW = 7;

    typedef struct packed {
        logic scl;
        logic sda;
    } sam_line_t;
endpackage

// File: rtl/sam_edge.sv
module sam_edge
    import sam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o
);
    sam_line_t line_d, line_q;

    always_comb begin
        line_d.scl = scl_i;
        line_d.sda = sda_i;
        start_o = line_q.scl & scl_i & line_q.sda & ~sda_i;
        stop_o  = line_q.scl & scl_i & ~line_q.sda & sda_i;
        rise_o  = ~line_q.scl & scl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '1;
        else        line_q <= line_d;
    end
endmodule

// File: rtl/sam_cmp.sv
module sam_cmp #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] cand_i,
    input  logic [AW-1:0] own_i,
    input  logic          en_i,
    output logic          hit_o
);
    always_comb hit_o = en_i & (cand_i == own_i);
endmodule

// File: rtl/sam_shift.sv
module sam_shift #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          rise_i,
    input  logic          sda_i,
    input  logic          hit_i,
    output logic [AW-1:0] cand_o,
    output logic          busy_o,
    output logic          match_o,
    output logic [AW-1:0] addr_o,
    output logic          rw_o
);
    localparam int CNT_W = $clog2(AW + 2);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(AW);

    typedef struct packed {
        logic [AW:0]      sh;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             match;
        logic [AW-1:0]    addr;
        logic             rw;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i || stop_i) begin
            st_d.busy  = 1'b0;
            st_d.match = 1'b0;
            st_d.cnt   = '0;
        end else if (start_i) begin
            st_d.busy  = 1'b1;
            st_d.match = 1'b0;
            st_d.cnt   = '0;
            st_d.sh    = '0;
        end else if (rise_i && st_q.busy) begin
            st_d.sh  = {st_q.sh[AW-1:0], sda_i};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy  = 1'b0;
                st_d.addr  = st_q.sh[AW-1:0];
                st_d.rw    = sda_i;
                st_d.match = hit_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cand_o  = st_q.sh[AW-1:0];
    assign busy_o  = st_q.busy;
    assign match_o = st_q.match;
    assign addr_o  = st_q.addr;
    assign rw_o    = st_q.rw;
endmodule

// File: rtl/addr_match_top.sv
module addr_match_top #(
    parameter int AW = sam_pkg::SAM_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [AW-1:0] own_addr_i,
    input  logic          match_en_i,
    input  logic          mod_en_i,
    output logic          match_o,
    output logic          busy_o,
    output logic [AW-1:0] addr_o,
    output logic          rw_o
);
    logic          start_w, stop_w, rise_w, hit_w;
    logic [AW-1:0] cand_w;

    sam_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start_w),
        .stop_o  (stop_w),
        .rise_o  (rise_w)
    );

    sam_cmp #(.AW(AW)) u_cmp (
        .cand_i (cand_w),
        .own_i  (own_addr_i),
        .en_i   (match_en_i),
        .hit_o  (hit_w)
    );

    sam_shift #(.AW(AW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (mod_en_i),
        .start_i (start_w),
        .stop_i  (stop_w),
        .rise_i  (rise_w),
        .sda_i   (sda_i),
        .hit_i   (hit_w),
        .cand_o  (cand_w),
        .busy_o  (busy_o),
        .match_o (match_o),
        .addr_o  (addr_o),
        .rw_o    (rw_o)
    );
endmodule

// File: rtl/sam_chk.sv
module sam_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_i,
    input logic [AW-1:0] own_addr_i,
    input logic          match_en_i,
    input logic          mod_en_i,
    input logic          match_o,
    input logic          busy_o,
    input logic [AW-1:0] addr_o,
    input logic          rw_o
);
    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en_i && scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> (busy_o && !match_o));

    a_r4_match_equals_own: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> (addr_o == $past(own_addr_i)));

    a_r5_match_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> $past(match_en_i));

    a_r6_busy_drops_with_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> $fell(busy_o));

    a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> (!busy_o && !match_o));

    a_r10_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en_i |=> (!busy_o && !match_o));

    a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy_o) |-> ($stable(addr_o) && $stable(rw_o)));
endmodule

bind addr_match_top sam_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .own_addr_i (own_addr_i),
    .match_en_i (match_en_i),
    .mod_en_i   (mod_en_i),
    .match_o    (match_o),
    .busy_o     (busy_o),
    .addr_o     (addr_o),
    .rw_o       (rw_o)
);

// File: tb/sim_addr_match_top.sv
`timescale 1ns/1ps
module sim_addr_match_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic [6:0] own = 7'h00;
    logic       men = 1'b0, ena = 1'b0;
    logic       match, busy, rw;
    logic [6:0] addr;
    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    addr_match_top u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .own_addr_i(own), .match_en_i(men), .mod_en_i(ena),
        .match_o(match), .busy_o(busy), .addr_o(addr), .rw_o(rw)
    );

    // behavioural reference
    bit   m_pscl = 1, m_psda = 1, m_busy = 0, m_match = 0, m_rw = 0;
    logic [6:0] m_addr = 0;
    bit   bits[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pscl = 1; m_psda = 1; m_busy = 0; m_match = 0; m_rw = 0; m_addr = 0;
            bits.delete();
        end else begin
            bit st, sp, rs;
            st = scl && m_pscl && m_psda && !sda;
            sp = scl && m_pscl && !m_psda && sda;
            rs = scl && !m_pscl;
            if (!ena || sp) begin
                m_busy = 0; m_match = 0; bits.delete();
            end else if (st) begin
                m_busy = 1; m_match = 0; bits.delete();
            end else if (rs && m_busy) begin
                bits.push_back(sda);
                if (bits.size() == 8) begin
                    logic [6:0] a;
                    a = 0;
                    for (int i = 0; i < 7; i++) a = {a[5:0], bits[i]};
                    m_addr = a; m_rw = bits[7];
                    m_match = men && (a == own);
                    m_busy = 0;
                end
            end
            m_pscl = scl; m_psda = sda;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!done) begin
        chk("R4 model match", 32'(match), 32'(m_match));
        chk("R6 model busy", 32'(busy), 32'(m_busy));
        chk("R3 model addr", 32'(addr), 32'(m_addr));
        chk("R7 model rw", 32'(rw), 32'(m_rw));
    end

    task automatic hold(); repeat (3) @(negedge clk); endtask
    task automatic bus_start();
        sda = 1; hold(); scl = 1; hold(); sda = 0; hold(); scl = 0; hold();
    endtask
    task automatic bus_stop();
        scl = 0; hold(); sda = 0; hold(); scl = 1; hold(); sda = 1; hold();
    endtask
    task automatic send_bit(bit b);
        sda = b; hold(); scl = 1; hold(); scl = 0; hold();
    endtask
    task automatic send_addr(logic [6:0] a, bit d);
        bus_start();
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
        send_bit(d);
        hold();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset match", 32'(match), 0);
        chk("R1 reset busy", 32'(busy), 0);
        chk("R1 reset addr", 32'(addr), 0);
        rst_n = 1;
        @(negedge clk);
        ena = 1; own = 7'h5A; men = 1;
        hold();
        // R2: busy after start
        sda = 1; hold(); scl = 1; hold(); sda = 0; hold();
        chk("R2 busy after start", 32'(busy), 1);
        scl = 0; hold();
        for (int i = 6; i >= 0; i--) send_bit(own[i]);
        chk("R6 busy before 8th bit", 32'(busy), 1);
        send_bit(1'b1); hold();
        chk("R6 busy dropped", 32'(busy), 0);
        chk("R4 match on equal", 32'(match), 1);
        chk("R3 addr captured", 32'(addr), 32'h5A);
        chk("R7 rw captured", 32'(rw), 1);
        // R11: extra clocks ignored
        send_bit(1'b0); send_bit(1'b0);
        chk("R11 addr held", 32'(addr), 32'h5A);
        chk("R11 match held", 32'(match), 1);
        bus_stop();
        chk("R9 stop clears match", 32'(match), 0);
        send_addr(7'h5B, 1'b1);
        chk("R4 mismatch last bit", 32'(match), 0);
        send_addr(7'h5A, 1'b0);
        chk("R7 rw ignored in compare", 32'(match), 1);
        chk("R7 rw zero", 32'(rw), 0);
        bus_stop();
        send_addr(7'h01, 1'b0);
        chk("R3 msb first", 32'(addr), 32'h01);
        bus_stop();
        men = 0;
        send_addr(7'h5A, 1'b1);
        chk("R5 no match when disabled", 32'(match), 0);
        bus_stop();
        men = 1;
        // R8: repeated start after partial address
        bus_start();
        send_bit(1); send_bit(1); send_bit(0);
        send_addr(7'h5A, 1'b0);
        chk("R8 repeated start match", 32'(match), 1);
        chk("R8 repeated start addr", 32'(addr), 32'h5A);
        bus_stop();
        // R9: stop mid-address
        bus_start();
        send_bit(0); send_bit(1);
        bus_stop();
        chk("R9 stop mid address busy", 32'(busy), 0);
        // R10: disable mid-address and while bus is active
        bus_start();
        send_bit(1); send_bit(0); send_bit(1);
        ena = 0; hold();
        chk("R10 disable clears busy", 32'(busy), 0);
        bus_stop();
        send_addr(7'h5A, 1'b1);
        chk("R10 ignored busy", 32'(busy), 0);
        chk("R10 ignored match", 32'(match), 0);
        chk("R10 addr kept", 32'(addr), 32'h5A);
        chk("R10 rw kept", 32'(rw), 0);
        bus_stop();
        ena = 1; hold();
        send_addr(7'h2C, 1'b1);
        own = 7'h2C; hold();
        chk("R4 own changed after phase", 32'(match), 0);
        bus_stop();
        send_addr(7'h2C, 1'b1);
        chk("R4 second address", 32'(match), 1);
        bus_stop();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule